// File: doc/BRIEF.md
# Multi-Channel Hit Timestamp Derandomizer

This block takes hit pulses from sixteen channels and turns them into one pushed stream of 16-bit words. Every channel stamps its hits with the value of a free-running counter in the front-end clock domain. It stores each stamp whole in a private four-entry queue that crosses into the readout clock domain. A scanner in the readout domain visits the channels in rotating order. It emits each stored hit as a burst of one to four words tagged with the channel number. There is no read request: a word is valid only in the readout cycle in which it appears.

The burst length is set through a small configuration input, and it trades time range against output bandwidth. One word carries 15 timestamp bits. Two, three and four words carry 31, 47 and 53 bits. Hits that come too soon after an accepted hit on the same channel are ignored. A hit that finds its channel's queue full is lost, and the loss raises a sticky per-channel flag that stays set until it is cleared. The readout clock is either the front-end clock divided by two or an external clock, chosen by a select input, and it is brought out beside the data.

Top module: `ts_derand`

## Requirements
- R1: After reset `out_valid` is 0, every `ovf_flags` bit is 0 and the burst length is 2 words.
- R2: A hit with timestamp T goes out as words in this order. Word 0 is {1'b1, T[14:0]}, word 1 is T[30:15], word 2 is T[46:31] and word 3 is {10'b0, T[52:47]}. `out_chan` holds the channel number on every word, and `out_last` is 1 only on the final word.
- R3: Writing `mode_sel` with `mode_we` high sets the burst length. The codes 0, 1, 2 and 3 give 1, 2, 3 and 4 words. The length is fixed when a hit's readout starts.
- R4: The words of one hit appear in consecutive readout cycles, with `out_valid` high throughout and `out_chan` unchanged.
- R5: The timestamp is the value of a front-end counter that reads 0 at the first front-end edge after reset and counts up by one on every edge. The counter is sampled at the edge where `hit[i]` is seen high.
- R6: After a hit is accepted on a channel, that channel ignores `hit` for the next DEAD_CYC-1 front-end cycles (DEAD_CYC = 7 by default).
- R7: Each channel queues at most 4 hits. An accepted hit that finds the queue full is dropped, and the channel's `ovf_flags` bit is set at the next front-end edge.
- R8: An `ovf_flags` bit stays set until `ovf_clr` for that channel is high at a front-end edge. If a drop and a clear fall on the same edge, the flag stays set.
- R9: The channels are served round-robin. The next hit comes from the first non-empty channel after the one served last, counting upward and wrapping from 15 to 0.
- R10: With `use_ext` at 0, `rd_clk` runs at half the `clk_fe` frequency. With `use_ext` at 1, `rd_clk` follows `clk_ext`.
- R11: Every stored hit is delivered exactly once, and hits of one channel come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fe | input | 1 | Front-end clock (timestamp counter, queue writes) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ext | input | 1 | External readout clock |
| use_ext | input | 1 | 1 selects `clk_ext` as the readout clock |
| hit | input | 16 | Per-channel hit level, sampled on `clk_fe` |
| mode_we | input | 1 | Loads `mode_sel` on `clk_fe` |
| mode_sel | input | 2 | Burst length minus one |
| ovf_clr | input | 16 | Per-channel overflow flag clear |
| ovf_flags | output | 16 | Sticky per-channel overflow flags |
| rd_clk | output | 1 | Readout clock that the output words follow |
| out_valid | output | 1 | Output word valid |
| out_last | output | 1 | Final word of a hit |
| out_chan | output | 4 | Channel of the current word |
| out_data | output | 16 | Output data word |

## Verification
Two things can fall on the same front-end edge: a hit that is dropped on a full queue, and a slow-control clear of that channel's flag. To provoke this, the readout clock is frozen so that nothing drains, one channel is filled to four entries, and the clear is driven in the very cycle of the fifth hit. The flag must then stay set, and it must drop only after a later clear on its own. In the readout domain, the last word of one hit and the pick of the next channel share a cycle. When the frozen clock is released with several channels loaded, the stream must run with no gap and follow the rotating order.

// File: rtl/ts_derand.sv
module ts_derand #(
  parameter int NCH = 16,
  parameter int TSW = 53,
  parameter int DEAD_CYC = 7,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk_fe,
  input  logic           rst_n,
  input  logic           clk_ext,
  input  logic           use_ext,
  input  logic [NCH-1:0] hit,
  input  logic           mode_we,
  input  logic [1:0]     mode_sel,
  input  logic [NCH-1:0] ovf_clr,
  output logic [NCH-1:0] ovf_flags,
  output logic           rd_clk,
  output logic           out_valid,
  output logic           out_last,
  output logic [CW-1:0]  out_chan,
  output logic [15:0]    out_data
);
  localparam int AW = 2;
  localparam int DCW = $clog2(DEAD_CYC);

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [TSW-1:0] tcnt;
  logic           clk_half;
  logic [1:0]     mode_q;

  always_ff @(posedge clk_fe or negedge rst_n)
    if (!rst_n) begin
      tcnt     <= '0;
      clk_half <= 1'b0;
      mode_q   <= 2'd1;
    end else begin
      tcnt     <= tcnt + 1'b1;
      clk_half <= ~clk_half;
      if (mode_we) mode_q <= mode_sel;
    end

  assign rd_clk = use_ext ? clk_ext : clk_half;

  logic [NCH-1:0] push, drop, nonempty;
  logic [TSW-1:0] head [NCH];
  logic           busy, found, pick, done;
  logic [1:0]     widx, nw_m1;
  logic [CW-1:0]  chan, sel;
  logic [TSW-1:0] hold_ts;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DCW-1:0] dcnt;
    logic [AW:0]    wbin, rbin, rs1, rs2, ws1, ws2;
    logic [TSW-1:0] mem [2**AW];
    logic           ovf_q, full, acc, pop;

    assign full = b2g(wbin) == {~rs2[AW:AW-1], rs2[AW-2:0]};
    assign acc  = hit[g] && (dcnt == '0);
    assign push[g] = acc && !full;
    assign drop[g] = acc && full;
    assign pop  = pick && (sel == CW'(g));
    assign nonempty[g] = b2g(rbin) != ws2;
    assign head[g] = mem[rbin[AW-1:0]];
    assign ovf_flags[g] = ovf_q;

    always_ff @(posedge clk_fe or negedge rst_n)
      if (!rst_n) begin
        dcnt  <= '0;
        wbin  <= '0;
        rs1   <= '0;
        rs2   <= '0;
        ovf_q <= 1'b0;
      end else begin
        rs1 <= b2g(rbin);
        rs2 <= rs1;
        if (acc) dcnt <= DCW'(DEAD_CYC - 1);
        else if (dcnt != '0) dcnt <= dcnt - 1'b1;
        if (push[g]) wbin <= wbin + 1'b1;
        if (drop[g]) ovf_q <= 1'b1;
        else if (ovf_clr[g]) ovf_q <= 1'b0;
      end

    always_ff @(posedge clk_fe)
      if (push[g]) mem[wbin[AW-1:0]] <= tcnt;

    always_ff @(posedge rd_clk or negedge rst_n)
      if (!rst_n) begin
        rbin <= '0;
        ws1  <= '0;
        ws2  <= '0;
      end else begin
        ws1 <= b2g(wbin);
        ws2 <= ws1;
        if (pop) rbin <= rbin + 1'b1;
      end
  end

  always_comb begin
    found = 1'b0;
    sel   = chan;
    for (int i = 1; i <= NCH; i++)
      if (!found && nonempty[(int'(chan) + i) % NCH]) begin
        found = 1'b1;
        sel   = CW'((int'(chan) + i) % NCH);
      end
  end

  assign done = busy && (widx == nw_m1);
  assign pick = found && (!busy || done);

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      busy    <= 1'b0;
      widx    <= '0;
      nw_m1   <= '0;
      chan    <= CW'(NCH - 1);
      hold_ts <= '0;
    end else if (pick) begin
      busy    <= 1'b1;
      widx    <= '0;
      nw_m1   <= mode_q;
      chan    <= sel;
      hold_ts <= head[sel];
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      widx <= widx + 1'b1;
    end

  logic [62:0] tsx;
  assign tsx = 63'(hold_ts);

  always_comb
    case (widx)
      2'd0:    out_data = {1'b1, tsx[14:0]};
      2'd1:    out_data = tsx[30:15];
      2'd2:    out_data = tsx[46:31];
      default: out_data = tsx[62:47];
    endcase

  assign out_valid = busy;
  assign out_last  = done;
  assign out_chan  = chan;

  // R4
  burst_gapless_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);

  // R4
  burst_chan_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    out_valid && !out_last |=> $stable(out_chan));

  // R6
  dead_time_chk: assert property (@(posedge clk_fe) disable iff (!rst_n)
    rst_n |=> ((push & $past(push)) == '0));

  // R7
  drop_flags_chk: assert property (@(posedge clk_fe) disable iff (!rst_n)
    (drop != '0) |=> ((ovf_flags & $past(drop)) == $past(drop)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk_fe) disable iff (!rst_n)
    rst_n |=> (($past(ovf_flags) & ~$past(ovf_clr) & ~ovf_flags) == '0));
endmodule

// File: tb/ts_derand_tb.sv
`timescale 1ns/1ps
module ts_derand_tb;
  localparam int NCH = 16;
  localparam int DEAD = 7;

  logic clk_fe = 0, rst_n = 0, clk_ext = 0, use_ext = 0, mode_we = 0;
  logic [1:0] mode_sel = 0;
  logic [15:0] hit = 0, ovf_clr = 0;
  wire [15:0] ovf_flags, out_data;
  wire rd_clk, out_valid, out_last;
  wire [3:0] out_chan;

  ts_derand u_dut (
    .clk_fe(clk_fe), .rst_n(rst_n), .clk_ext(clk_ext), .use_ext(use_ext),
    .hit(hit), .mode_we(mode_we), .mode_sel(mode_sel), .ovf_clr(ovf_clr),
    .ovf_flags(ovf_flags), .rd_clk(rd_clk), .out_valid(out_valid),
    .out_last(out_last), .out_chan(out_chan), .out_data(out_data));

  always #2.5 clk_fe = ~clk_fe;

  bit ext_run = 0;
  always begin
    if (ext_run) begin #7 clk_ext = 1; #7 clk_ext = 0; end
    else #1;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wexp(input longint unsigned ts, input int k);
    logic [63:0] v;
    v = 64'(ts);
    if (k == 0) return {1'b1, v[14:0]};
    return v[16*k-1 +: 16];
  endfunction

  // behavioural reference model
  longint unsigned q [NCH][$];
  longint t = 0;
  longint last_acc [NCH];
  logic [15:0] exp_flags = 0;

  always @(posedge clk_fe) if (rst_n) begin
    for (int c = 0; c < NCH; c++) begin
      bit dr;
      dr = 0;
      if (hit[c] && (t - last_acc[c] >= DEAD)) begin
        last_acc[c] = t;
        if (q[c].size() < 4) q[c].push_back(longint'(t));
        else dr = 1;
      end
      if (dr) exp_flags[c] = 1'b1;
      else if (ovf_clr[c]) exp_flags[c] = 1'b0;
    end
    t++;
  end

  always @(negedge clk_fe)
    if (rst_n && !finished)
      chk(ovf_flags == exp_flags, "R7 R8 overflow flags", ovf_flags, exp_flags);

  int cur_k = 0, cur_nw = 2, exp_nw = 2, last_srv = NCH - 1, cur_c = 0;
  longint unsigned cur_ts = 0;
  bit rr_phase = 0;

  always @(negedge rd_clk) begin
    #1;
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (cur_k == 0) begin
          if (rr_phase) begin
            int e;
            e = -1;
            for (int i = 1; i <= NCH; i++)
              if (e < 0 && q[(last_srv + i) % NCH].size() > 0) e = (last_srv + i) % NCH;
            chk(int'(out_chan) == e, "R9 round-robin order", out_chan, e);
          end
          cur_c = out_chan;
          last_srv = cur_c;
          cur_nw = exp_nw;
          if (q[cur_c].size() == 0) begin
            chk(0, "R6 R11 unexpected hit", cur_c, -1);
            cur_ts = 0;
          end else cur_ts = q[cur_c].pop_front();
        end
        chk(out_data == wexp(cur_ts, cur_k), "R2 R5 word data", out_data, wexp(cur_ts, cur_k));
        chk(int'(out_chan) == cur_c, "R2 R4 channel tag", out_chan, cur_c);
        chk(out_last == (cur_k == cur_nw - 1), "R2 R3 last marker", out_last, (cur_k == cur_nw - 1));
        cur_k = (cur_k == cur_nw - 1) ? 0 : cur_k + 1;
      end else if (cur_k != 0) begin
        chk(0, "R4 gap inside a hit", 0, 1);
        cur_k = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_fe);
  endtask

  task automatic pulse(input logic [15:0] m, input logic [15:0] clr);
    @(negedge clk_fe); hit = m; ovf_clr = clr;
    @(negedge clk_fe); hit = 0; ovf_clr = 0;
  endtask

  task automatic set_mode(input int nw);
    @(negedge clk_fe); mode_sel = 2'(nw - 1); mode_we = 1;
    @(negedge clk_fe); mode_we = 0; exp_nw = nw;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    realtime t0;
    for (int c = 0; c < NCH; c++) last_acc[c] = -1000;
    repeat (4) @(negedge clk_fe);
    rst_n = 1;
    @(negedge clk_fe);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(ovf_flags == 0, "R1 flags after reset", ovf_flags, 0);

    @(posedge rd_clk); t0 = $realtime;
    @(posedge rd_clk);
    chk(int'(($realtime - t0) * 1000) == 10000, "R10 half-rate readout period", int'(($realtime - t0) * 1000), 10000);

    // default 2-word bursts (R1), single and simultaneous channels
    pulse(16'h0020, 0); idle(40);
    pulse(16'h0007, 0); idle(60);
    pulse(16'h8001, 0); idle(40);

    // R6 dead time: level held 10 cycles, then 2-cycle pulse at +6/+7
    @(negedge clk_fe); hit = 16'h0080; idle(10); hit = 0; idle(30);
    pulse(16'h0010, 0); idle(4);
    @(negedge clk_fe); hit = 16'h0010; idle(2); hit = 0; idle(40);

    // R3 every burst length
    for (int nw = 1; nw <= 4; nw++) begin
      set_mode(nw);
      pulse(16'h1248, 0); idle(80);
    end

    // R2 R5 upper timestamp bits
    set_mode(2); idle(33000);
    pulse(16'h0400, 0); idle(40);
    set_mode(3); pulse(16'h0400, 0); idle(40);
    set_mode(4); pulse(16'h0400, 0); idle(40);
    set_mode(1); pulse(16'h0400, 0); idle(40);

    // R7 R8 R9: frozen readout, fill channel 9, clear on the drop cycle
    @(negedge rd_clk); use_ext = 1; idle(10);
    for (int k = 0; k < 6; k++) begin
      pulse(16'h0200 | ((k < 2) ? 16'h4005 : 16'h0000), (k == 4) ? 16'h0200 : 16'h0000);
      if (k == 4) chk(ovf_flags[9] == 1, "R8 set wins over same-cycle clear", ovf_flags[9], 1);
      if (k == 3) chk(ovf_flags[9] == 0, "R7 no flag at four entries", ovf_flags[9], 0);
      idle(8);
    end
    chk(ovf_flags == 16'h0200, "R7 only the full channel flagged", ovf_flags, 16'h0200);
    pulse(0, 16'h0200); idle(2);
    chk(ovf_flags == 0, "R8 clear alone", ovf_flags, 0);
    rr_phase = 1; use_ext = 0; idle(80); rr_phase = 0;

    // R10 external readout clock
    @(negedge rd_clk); use_ext = 1; idle(4); ext_run = 1;
    @(posedge rd_clk); t0 = $realtime;
    @(posedge rd_clk);
    chk(int'(($realtime - t0) * 1000) == 14000, "R10 external readout period", int'(($realtime - t0) * 1000), 14000);
    set_mode(2);
    pulse(16'h2101, 0); idle(80);
    ext_run = 0; #20; use_ext = 0; idle(40);

    for (int c = 0; c < NCH; c++)
      chk(q[c].size() == 0, "R11 all hits delivered", q[c].size(), 0);
    chk(cur_k == 0, "R4 no burst left open", cur_k, 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule